// File: doc/BRIEF.md
# Display RAM host access controller

This block gives a host processor access to a 16-row by 8-bit memory that a display scan engine reads to refresh its digits. The host uses chip select, read and write strobes, a one-bit register select (A0) and an 8-bit data bus. A write with A0 high is a command. A write with A0 low stores a byte in display memory. A read with A0 high returns a status byte. A read with A0 low returns display memory data once display memory has been chosen as the read source.

A single row pointer serves both data reads and data writes. Two commands load it: one also selects display memory as the read source, the other leaves the read source alone. Each command also sets an auto-increment flag. Separate flags for the upper and lower nibble can protect that nibble from host writes, or replace it with the blank code on the scan port. A clear command chooses the blank code. It can also start a timed fill that writes the blank code into every row. While the fill runs, the status MSB reads 1 and host data writes are dropped.

Top module: `dispram_host_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00. A data read (A0=0) returns 0x00 because display memory is not yet the read source. Every row reads 0x00, and the blank code is 0x00.
- R2: Command 011 I RRRR (bits 7:5 = 011, bit 4 = I auto-increment, bits 3:0 = row) loads the pointer and the auto-increment flag, and selects display memory as the read source. A data read then returns the row at the pointer.
- R3: With auto-increment set, the pointer advances by one after each data read from display memory (on the rising edge of RD) and after each accepted data write (on the rising edge of WR). It wraps from 15 to 0. With auto-increment clear, the pointer holds.
- R4: A data write (A0=0) always stores the byte in the row at the pointer, whatever the current read source.
- R5: Command 100 I RRRR loads the same pointer and auto-increment flag but does not change the read source. Before any 011 command, data reads still return 0x00. Once display memory is the read source, the command moves the next read location.
- R6: Command 101 x P Q s t: bit 3 (P) protects the upper nibble (D7..D4) and bit 2 (Q) protects the lower nibble (D3..D0). A protected nibble keeps its old value when the host writes the row.
- R7: In the same command, bit 1 (s) blanks the upper nibble and bit 0 (t) blanks the lower nibble. A blanked nibble is replaced by the matching nibble of the blank code on the scan port only. Host data reads still return the stored value.
- R8: Command 110 C1 C0 E F K latches the blank code every time it is written. C1C0 = 0x gives 0x00, 10 gives 0x20 and 11 gives 0xFF. The fill starts when E (bit 2) or K (bit 0) is 1. With both at 0, nothing starts and the status stays 0x00. Bit F is accepted and has no effect.
- R9: A fill writes the blank code into all 16 rows, one row every CLEAR_CYCLES/16 clocks, with CLEAR_CYCLES a multiple of 16. The status MSB is 1 for exactly CLEAR_CYCLES clock cycles after the command's WR edge and then returns to 0 by itself.
- R10: A host data write made while a fill runs is dropped. It changes no row and does not move the pointer.
- R11: A status read (CS=0, RD=0, A0=1) returns {busy, 0000000}. With CS or RD high, the data output is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the host strobes are sampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low; acts on its rising edge |
| a0 | input | 1 | Register select: 1 = command/status, 0 = data |
| dataIn | input | 8 | Host write data |
| dataOut | output | 8 | Host read data, 0x00 when no read is under way |
| scanAddr | input | 4 | Row requested by the display scan engine |
| scanData | output | 8 | Row contents after nibble blanking |

## Verification
The assertions check four things on every cycle. The status byte and the idle bus value are checked against the fill state. The busy flag must drop exactly CLEAR_CYCLES cycles after it rose, and only just after the last row is written. Any memory write made while busy must carry the blank code. A blanked nibble on the scan port must show the blank code. The directed scenarios show the rest. The shared pointer must behave correctly with each kind of command. Auto-increment must hold or advance, and wrap at the top row. Nibble protection must keep the old values. Reads must stay raw while the scan port is blanked. A write dropped during a fill must leave both memory and pointer alone. Those effects only appear across sequences of host cycles.

// File: rtl/dispram_pkg.sv
package dispram_pkg;
  localparam int ROWS   = 16;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int LANES  = BYTE_W / NIB_W;

  typedef enum logic [2:0] {
    OP_RD_DISP = 3'b011,
    OP_WR_DISP = 3'b100,
    OP_MASK    = 3'b101,
    OP_CLEAR   = 3'b110
  } hostOp_e;

  typedef enum logic [1:0] {
    RDSEL_NONE   = 2'd0,
    RDSEL_STATUS = 2'd1,
    RDSEL_RAM    = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic              wrEn;
    logic [ROW_W-1:0]  wrAddr;
    logic [BYTE_W-1:0] wrData;
    logic              keepHi;
    logic              keepLo;
    logic [ROW_W-1:0]  rdAddr;
    rdSel_e            rdSel;
    logic              statusBusy;
    logic              blankHi;
    logic              blankLo;
    logic [BYTE_W-1:0] blankCode;
  } ramStrobe_t;
endpackage

// File: rtl/dispram_ctrl.sv
module dispram_ctrl
  import dispram_pkg::*;
#(
  parameter int CLEAR_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              a0,
  input  logic [BYTE_W-1:0] dataIn,
  output ramStrobe_t        strobe
);
  localparam int ROW_TICKS = (CLEAR_CYCLES / ROWS < 1) ? 1 : CLEAR_CYCLES / ROWS;
  localparam int TICK_W    = $clog2(ROW_TICKS + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(ROW_TICKS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);

  logic              wrPrev, rdPrev;
  logic [ROW_W-1:0]  ptr;
  logic              autoInc;
  logic              srcDisp;
  logic              inhHi, inhLo, blkHi, blkLo;
  logic [BYTE_W-1:0] blankCode;
  logic              busy;
  logic [ROW_W-1:0]  rowCnt;
  logic [TICK_W-1:0] tickCnt;

  logic              wrRise, rdRise, cmdWr, dataWr, dataRd, cpuWrOk;
  logic              rowTick, clearGo, loadPtr;
  hostOp_e           opcode;
  logic [BYTE_W-1:0] codeSel;

  // Strobe edges: a host cycle acts when its strobe returns high
  assign wrRise  = !wrPrev && wrN && !csN;
  assign rdRise  = !rdPrev && rdN && !csN;
  assign cmdWr   = wrRise && a0;
  assign dataWr  = wrRise && !a0;
  assign dataRd  = rdRise && !a0;
  assign cpuWrOk = dataWr && !busy;
  assign opcode  = hostOp_e'(dataIn[BYTE_W-1:BYTE_W-3]);
  assign loadPtr = cmdWr && (opcode == OP_RD_DISP || opcode == OP_WR_DISP);
  assign clearGo = cmdWr && (opcode == OP_CLEAR) && (dataIn[2] || dataIn[0]) && !busy;
  assign rowTick = busy && (tickCnt == TICK_LAST);

  always_comb begin
    case (dataIn[4:3])
      2'b10:   codeSel = BYTE_W'(8'h20);
      2'b11:   codeSel = {BYTE_W{1'b1}};
      default: codeSel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b1;
      rdPrev <= 1'b1;
    end else begin
      wrPrev <= wrN;
      rdPrev <= rdN;
    end
  end

  // Shared row pointer, auto-increment flag and read source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      autoInc <= 1'b0;
      srcDisp <= 1'b0;
    end else begin
      if (loadPtr) begin
        ptr     <= dataIn[ROW_W-1:0];
        autoInc <= dataIn[ROW_W];
        if (opcode == OP_RD_DISP) srcDisp <= 1'b1;
      end else if (autoInc && (cpuWrOk || (dataRd && srcDisp))) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // Nibble protect / blank flags and blank code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inhHi     <= 1'b0;
      inhLo     <= 1'b0;
      blkHi     <= 1'b0;
      blkLo     <= 1'b0;
      blankCode <= '0;
    end else if (cmdWr) begin
      if (opcode == OP_MASK) begin
        inhHi <= dataIn[3];
        inhLo <= dataIn[2];
        blkHi <= dataIn[1];
        blkLo <= dataIn[0];
      end
      if (opcode == OP_CLEAR) blankCode <= codeSel;
    end
  end

  // Timed fill sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      rowCnt  <= '0;
      tickCnt <= '0;
    end else if (clearGo) begin
      busy    <= 1'b1;
      rowCnt  <= '0;
      tickCnt <= '0;
    end else if (busy) begin
      if (rowTick) begin
        tickCnt <= '0;
        rowCnt  <= rowCnt + 1'b1;
        if (rowCnt == ROW_LAST) busy <= 1'b0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.wrEn       = busy ? rowTick : cpuWrOk;
    strobe.wrAddr     = busy ? rowCnt : ptr;
    strobe.wrData     = busy ? blankCode : dataIn;
    strobe.keepHi     = !busy && inhHi;
    strobe.keepLo     = !busy && inhLo;
    strobe.rdAddr     = ptr;
    strobe.statusBusy = busy;
    strobe.blankHi    = blkHi;
    strobe.blankLo    = blkLo;
    strobe.blankCode  = blankCode;
    if (!csN && !rdN)
      strobe.rdSel = a0 ? RDSEL_STATUS : (srcDisp ? RDSEL_RAM : RDSEL_NONE);
    else
      strobe.rdSel = RDSEL_NONE;
  end
endmodule

// File: rtl/dispram_data.sv
module dispram_data
  import dispram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobe_t        strobe,
  input  logic [ROW_W-1:0]  scanAddr,
  output logic [BYTE_W-1:0] dataOut,
  output logic [BYTE_W-1:0] scanData
);
  logic [BYTE_W-1:0] rdRaw;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [NIB_W-1:0] mem [ROWS];
    logic             keep;
    logic             blank;

    assign keep  = (n == LANES - 1) ? strobe.keepHi : strobe.keepLo;
    assign blank = (n == LANES - 1) ? strobe.blankHi : strobe.blankLo;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < ROWS; r++) mem[r] <= '0;
      end else if (strobe.wrEn && !keep) begin
        mem[strobe.wrAddr] <= strobe.wrData[n*NIB_W +: NIB_W];
      end
    end

    assign rdRaw[n*NIB_W +: NIB_W]    = mem[strobe.rdAddr];
    assign scanData[n*NIB_W +: NIB_W] = blank ? strobe.blankCode[n*NIB_W +: NIB_W]
                                              : mem[scanAddr];
  end

  always_comb begin
    case (strobe.rdSel)
      RDSEL_STATUS: dataOut = {strobe.statusBusy, {(BYTE_W-1){1'b0}}};
      RDSEL_RAM:    dataOut = rdRaw;
      default:      dataOut = '0;
    endcase
  end
endmodule

// File: rtl/dispram_host_ctrl.sv
module dispram_host_ctrl
  import dispram_pkg::*;
#(
  parameter int CLEAR_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              a0,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [BYTE_W-1:0] dataOut,
  input  logic [ROW_W-1:0]  scanAddr,
  output logic [BYTE_W-1:0] scanData
);
  ramStrobe_t strobe;

  dispram_ctrl #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .rdN    (rdN),
    .wrN    (wrN),
    .a0     (a0),
    .dataIn (dataIn),
    .strobe (strobe)
  );

  dispram_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .scanAddr (scanAddr),
    .dataOut  (dataOut),
    .scanData (scanData)
  );
endmodule

// File: rtl/dispram_host_ctrl_chk.sv
module dispram_host_ctrl_chk
  import dispram_pkg::*;
#(
  parameter int CLEAR_CYCLES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic              a0,
  input logic [BYTE_W-1:0] dataOut,
  input logic [BYTE_W-1:0] scanData,
  input logic              wrEn,
  input logic [ROW_W-1:0]  wrAddr,
  input logic [BYTE_W-1:0] wrData,
  input logic              busy,
  input logic              blankHi,
  input logic              blankLo,
  input logic [BYTE_W-1:0] blankCode
);
  localparam int CNT_W = $clog2(CLEAR_CYCLES + 2);
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else       busyCnt <= busy ? busyCnt + 1'b1 : '0;
  end

  assert_status_word_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rdN && a0) |-> dataOut == {busy, {(BYTE_W-1){1'b0}}});

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> dataOut == '0);

  assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_W'(CLEAR_CYCLES));

  assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyCnt == CNT_W'(CLEAR_CYCLES));

  assert_fill_ends_last_row_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(wrEn) && $past(wrAddr) == ROW_W'(ROWS - 1)));

  assert_busy_write_is_fill_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |-> wrData == blankCode);

  assert_blank_hi_R7: assert property (@(posedge clk) disable iff (!rstN)
    blankHi |-> scanData[BYTE_W-1:NIB_W] == blankCode[BYTE_W-1:NIB_W]);

  assert_blank_lo_R7: assert property (@(posedge clk) disable iff (!rstN)
    blankLo |-> scanData[NIB_W-1:0] == blankCode[NIB_W-1:0]);
endmodule

bind dispram_host_ctrl dispram_host_ctrl_chk #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .rdN       (rdN),
  .a0        (a0),
  .dataOut   (dataOut),
  .scanData  (scanData),
  .wrEn      (strobe.wrEn),
  .wrAddr    (strobe.wrAddr),
  .wrData    (strobe.wrData),
  .busy      (strobe.statusBusy),
  .blankHi   (strobe.blankHi),
  .blankLo   (strobe.blankLo),
  .blankCode (strobe.blankCode)
);

// File: tb/dispram_host_ctrl_tb.sv
`timescale 1ns/1ps
module dispram_host_ctrl_tb;
  localparam int CLEAR_CYCLES = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1, a0 = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic [3:0] scanAddr = '0;
  logic [7:0] scanData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dispram_host_ctrl #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .a0(a0),
    .dataIn(dataIn), .dataOut(dataOut), .scanAddr(scanAddr), .scanData(scanData)
  );

  task automatic checkEq(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [7:0] d);
    @(negedge clk); csN = 1'b0; a0 = sel; dataIn = d; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); csN = 1'b1;
  endtask

  task automatic hostRead(input logic sel, output logic [7:0] d);
    @(negedge clk); csN = 1'b0; a0 = sel; rdN = 1'b0;
    @(negedge clk); d = dataOut; rdN = 1'b1;
    @(negedge clk); csN = 1'b1;
  endtask

  task automatic scanCheck(input string req, input logic [3:0] row, input logic [7:0] exp);
    scanAddr = row; #1;
    checkEq(req, scanData, exp);
  endtask

  task automatic testReset();
    logic [7:0] v;
    hostRead(1'b1, v); checkEq("R1 status after reset", v, 8'h00);
    hostRead(1'b0, v); checkEq("R1 data read before source select", v, 8'h00);
    scanCheck("R1 row 0 after reset", 4'd0, 8'h00);
    @(negedge clk); checkEq("R11 idle bus", dataOut, 8'h00);
  endtask

  task automatic testSharedPointer();
    logic [7:0] v;
    hostWrite(1'b1, 8'h82);            // write-display row 2, no auto-increment
    hostWrite(1'b0, 8'h77);
    hostRead(1'b0, v); checkEq("R5 source unchanged by write-display", v, 8'h00);
    scanCheck("R4 write lands before source select", 4'd2, 8'h77);
    hostWrite(1'b1, 8'h62);            // read-display row 2
    hostRead(1'b0, v); checkEq("R2 read-display row 2", v, 8'h77);
    hostWrite(1'b1, 8'h84);            // write-display row 4 moves read location
    hostRead(1'b0, v); checkEq("R5 write-display moves read pointer", v, 8'h00);
  endtask

  task automatic testAutoInc();
    logic [7:0] v;
    hostWrite(1'b1, 8'h98);            // write-display row 8, auto-increment
    hostWrite(1'b0, 8'h81);
    hostWrite(1'b0, 8'h82);
    scanCheck("R3 write increments to row 9", 4'd9, 8'h82);
    hostWrite(1'b1, 8'h78);            // read-display row 8, auto-increment
    hostRead(1'b0, v); checkEq("R3 first read row 8", v, 8'h81);
    hostRead(1'b0, v); checkEq("R3 read increments to row 9", v, 8'h82);
    hostWrite(1'b1, 8'h68);            // read-display row 8, hold
    hostRead(1'b0, v); checkEq("R3 hold read 1", v, 8'h81);
    hostRead(1'b0, v); checkEq("R3 hold read 2", v, 8'h81);
    hostWrite(1'b1, 8'h9F);            // write-display row 15, auto-increment
    hostWrite(1'b0, 8'h11);
    hostWrite(1'b0, 8'h22);
    scanCheck("R3 row 15 before wrap", 4'd15, 8'h11);
    scanCheck("R3 wrap to row 0", 4'd0, 8'h22);
  endtask

  task automatic testInhibit();
    hostWrite(1'b1, 8'h83);
    hostWrite(1'b0, 8'h5A);
    hostWrite(1'b1, 8'hA8);            // protect upper nibble
    hostWrite(1'b0, 8'hC3);
    scanCheck("R6 upper nibble kept", 4'd3, 8'h53);
    hostWrite(1'b1, 8'hA4);            // protect lower nibble
    hostWrite(1'b0, 8'h96);
    scanCheck("R6 lower nibble kept", 4'd3, 8'h93);
    hostWrite(1'b1, 8'hA0);
  endtask

  task automatic testBlank();
    logic [7:0] v;
    hostWrite(1'b1, 8'hA2);            // blank upper nibble, code 0x00
    scanCheck("R7 upper blank with code 00", 4'd3, 8'h03);
    hostWrite(1'b1, 8'hD8);            // code 0xFF, no start
    hostRead(1'b1, v); checkEq("R8 code latch without start", v, 8'h00);
    scanCheck("R8 code FF on upper nibble", 4'd3, 8'hF3);
    hostWrite(1'b1, 8'hA3);            // blank both nibbles
    scanCheck("R7 both nibbles blanked", 4'd3, 8'hFF);
    hostWrite(1'b1, 8'h63);
    hostRead(1'b0, v); checkEq("R7 host read stays raw", v, 8'h93);
    hostWrite(1'b1, 8'hCA);            // code 01 -> 0x00, F bit set, no start
    scanCheck("R8 code 01 gives 00", 4'd3, 8'h00);
    hostWrite(1'b1, 8'hA0);
    scanCheck("R7 blank removed", 4'd3, 8'h93);
  endtask

  task automatic testClear();
    logic [7:0] v;
    hostWrite(1'b1, 8'h75);            // read-display row 5, auto-increment
    hostWrite(1'b1, 8'hDC);            // code FF, enable fill
    hostRead(1'b1, v); checkEq("R9 busy right after start", v, 8'h80);
    hostWrite(1'b0, 8'h12);            // dropped
    repeat (CLEAR_CYCLES - 9) @(negedge clk);
    csN = 1'b0; a0 = 1'b1; rdN = 1'b0;
    @(negedge clk);
    @(negedge clk); checkEq("R9 busy in last fill cycle", dataOut, 8'h80);
    @(negedge clk); checkEq("R9 busy drops after CLEAR_CYCLES", dataOut, 8'h00);
    rdN = 1'b1;
    @(negedge clk); csN = 1'b1;
    begin
      int bad = 0;
      for (int r = 0; r < 16; r++) begin
        scanAddr = 4'(r); #1;
        if (scanData !== 8'hFF) bad++;
      end
      checkEq("R9 all rows hold FF", 8'(bad), 8'h00);
    end
    hostWrite(1'b0, 8'hA5);
    hostWrite(1'b1, 8'h65);
    hostRead(1'b0, v); checkEq("R10 pointer not moved by dropped write", v, 8'hA5);
    hostWrite(1'b1, 8'h66);
    hostRead(1'b0, v); checkEq("R10 dropped write left row 6", v, 8'hFF);
    hostWrite(1'b1, 8'hD1);            // code 0x20 via clear-all bit
    hostRead(1'b1, v); checkEq("R8 clear-all bit starts fill", v, 8'h80);
    repeat (CLEAR_CYCLES + 4) @(negedge clk);
    hostRead(1'b1, v); checkEq("R9 fill finished", v, 8'h00);
    scanCheck("R8 code 20 row 5", 4'd5, 8'h20);
    scanCheck("R8 code 20 row 0", 4'd0, 8'h20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSharedPointer();
    testAutoInc();
    testInhibit();
    testBlank();
    testClear();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule